// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a watchdog timer with two 16-bit registers behind a plain write-strobe and read-data interface. A control register holds a timeout field and an enable bit. A service register restarts the countdown, but only when two key values arrive in the correct order. The timeout is counted in half-second ticks. A prescaler divides the system clock by a parameter to produce those ticks.

Software programs a timeout field value N to get a period of (N+1) ticks, so a period of S seconds is written as 2*S-1. Once the watchdog is enabled, software cannot turn it off. If the count runs out, the block raises a reset request and holds it until the system reset clears the block.

Top module: `wdt_keyed`

## Requirements
- R1: After reset, the control register reads 0x0000 and the reset request is low.
- R2: The control register is at address 0. Bits [7:0] hold the timeout field and bit 8 holds the enable bit. Bits [15:9] always read 0, and a write stores bits [8:0] only.
- R3: Once the enable bit is 1, writing 0 to it has no effect until the next reset. The timeout field can still be rewritten.
- R4: When the enable bit rises through a write carrying field value N, the counter loads N and the prescaler restarts. The reset request then rises exactly (N+1)*TICK_DIV clock edges after that write edge.
- R5: The service register is at address 1. Writing 0x5555 and then 0x AAAA to it reloads the counter from the timeout field and restarts the prescaler. The next expiry is then (N+1)*TICK_DIV edges after the second write.
- R6: Writing 0xAAAA without a pending 0x5555 does nothing. Any other value written to the service register between the two keys cancels the pending 0x5555.
- R7: A timeout field rewritten while the watchdog is running leaves the current countdown unchanged. The new value takes effect at the next reload.
- R8: Once the reset request is high, it stays high until reset, including through service sequences.
- R9: Reading the service register returns 0x0000.
- R10: While the enable bit is 0, the reset request never rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| addr | input | 1 | Register select: 0 selects control, 1 selects service |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for the register selected by addr (combinational) |
| rst_req | output | 1 | Reset request, held high after expiry |

## Verification
The bench builds the block with TICK_DIV set to 4, so one half-second tick lasts four clock cycles. With this setting, a whole countdown fits in a few dozen cycles, and every expiry edge can be checked to the exact cycle. The short tick also makes it practical to run separate reset-to-expiry runs for the service sequence, a lone second key, a cancelled key, and a timeout rewrite.

// File: rtl/wdt_keyed.sv
module wdt_keyed #(
  parameter int TICK_DIV = 62_500_000,
  parameter logic [15:0] KEY_A = 16'h5555,
  parameter logic [15:0] KEY_B = 16'hAAAA
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  output logic        rst_req
);
  localparam int PW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] PMAX = PW'(TICK_DIV - 1);

  logic          en;
  logic [7:0]    tmo;
  logic [7:0]    cnt;
  logic [PW-1:0] pre;
  logic          armed;

  wire ctl_wr   = wr_en && !addr;
  wire svc_wr   = wr_en && addr;
  wire en_rise  = ctl_wr && wdata[8] && !en;
  wire svc_done = svc_wr && armed && (wdata == KEY_B);
  wire reload   = en_rise || svc_done;
  wire tick     = (pre == PMAX);

  assign rdata = addr ? 16'h0000 : {7'b0, en, tmo};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en  <= 1'b0;
      tmo <= 8'h00;
    end else if (ctl_wr) begin
      en  <= en | wdata[8];
      tmo <= wdata[7:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      armed <= 1'b0;
    else if (svc_wr) armed <= (wdata == KEY_A);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= 8'h00;
      pre     <= '0;
      rst_req <= 1'b0;
    end else if (!rst_req) begin
      if (reload) begin
        cnt <= en_rise ? wdata[7:0] : tmo;
        pre <= '0;
      end else if (en) begin
        pre <= tick ? '0 : pre + 1'b1;
        if (tick) begin
          if (cnt == 8'h00) rst_req <= 1'b1;
          else              cnt <= cnt - 1'b1;
        end
      end
    end
  end

  AST_EN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> en); // R3
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> rst_req); // R8
  AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> en); // R10
  AST_SVC_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    addr |-> (rdata == 16'h0000)); // R9
  AST_SVC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_done && !rst_req) |=> (cnt == $past(tmo))); // R5
  AST_RISE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (en_rise && !rst_req) |=> (cnt == $past(wdata[7:0]) && pre == '0)); // R4
endmodule

// File: tb/test_wdt_keyed.sv
module test_wdt_keyed;
  localparam int D = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        addr = 1'b0;
  logic [15:0] wdata = 16'h0000;
  logic [15:0] rdata;
  logic        rst_req;

  int n_vec = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  wdt_keyed #(.TICK_DIV(D)) i_wdt_keyed (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rst_req(rst_req)
  );

  // {addr, write data, expected read of the same address after the write}
  localparam int NV = 8;
  localparam logic [32:0] VEC [NV] = '{
    {1'b0, 16'h0012, 16'h0012},   // R2
    {1'b0, 16'hFE34, 16'h0034},   // R2
    {1'b1, 16'h5555, 16'h0000},   // R9
    {1'b1, 16'h1234, 16'h0000},   // R9
    {1'b0, 16'h01C8, 16'h01C8},   // R2
    {1'b0, 16'h0005, 16'h0105},   // R3
    {1'b0, 16'h00FF, 16'h01FF},   // R3
    {1'b1, 16'hAAAA, 16'h0000}    // R9
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; wr_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; addr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_rise(input string req, input int m_now, input int m_rise);
    idle(m_rise - 1 - m_now);
    chk(req, {15'b0, rst_req}, 16'h0000);
    idle(1);
    chk(req, {15'b0, rst_req}, 16'h0001);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    addr = 1'b0; #1;
    chk("R1", rdata, 16'h0000);
    chk("R1", {15'b0, rst_req}, 16'h0000);
    addr = 1'b1; #1;
    chk("R9", rdata, 16'h0000);
    addr = 1'b0;

    @(negedge clk);
    wr(1'b0, 16'h0000);
    idle(50);
    chk("R10", {15'b0, rst_req}, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][32], VEC[i][31:16]);
      addr = VEC[i][32]; #1;
      chk("R2/R3/R9 vector", rdata, VEC[i][15:0]);
      addr = 1'b0;
    end

    do_reset(); @(negedge clk);
    wr(1'b0, 16'h0102);
    expect_rise("R4", 0, 3*D);
    wr(1'b1, 16'h5555);
    wr(1'b1, 16'hAAAA);
    wr(1'b0, 16'h0000);
    idle(40);
    chk("R8", {15'b0, rst_req}, 16'h0001);
    #1; chk("R8", rdata, 16'h0100);

    do_reset(); @(negedge clk);
    wr(1'b0, 16'h0103);
    idle(9);
    wr(1'b1, 16'h5555);
    wr(1'b1, 16'hAAAA);
    expect_rise("R5", 0, 4*D);

    do_reset(); @(negedge clk);
    wr(1'b0, 16'h0103);
    idle(5);
    wr(1'b1, 16'hAAAA);
    expect_rise("R6", 6, 4*D);

    do_reset(); @(negedge clk);
    wr(1'b0, 16'h0103);
    wr(1'b1, 16'h5555);
    wr(1'b1, 16'h1234);
    wr(1'b1, 16'hAAAA);
    expect_rise("R6", 3, 4*D);

    do_reset(); @(negedge clk);
    wr(1'b0, 16'h0103);
    wr(1'b0, 16'h0009);
    expect_rise("R7", 1, 4*D);

    do_reset(); @(negedge clk);
    wr(1'b0, 16'h0103);
    wr(1'b0, 16'h0009);
    idle(6);
    wr(1'b1, 16'h5555);
    wr(1'b1, 16'hAAAA);
    expect_rise("R7", 0, 10*D);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule